// File: doc/BRIEF.md
# TDM Time-Slot Routing Sequencer

This block routes the byte slots of a serial time-division-multiplexed frame to five serial channels. Each frame begins at a frame sync. From then on a sequencer reads a routing table one entry at a time. Each entry gives a run of consecutive byte slots to one channel, or marks the run as unused. Entries are read until one carries an end-of-frame flag. The walk then stops and waits for the next sync. Receive and transmit each have their own table region, their own sequencer, and their own bit clock and sync input. On receive, the block deserializes each byte and, when the slot belongs to a channel, pulses that channel's strobe together with the byte. On transmit, it pulses a per-channel request at the start of each slot that the channel owns, so the channel can supply its byte in time.

The TDM bit clock and sync lines are sampled by the system clock, and their edges are detected there. This allows a run-time choice of which bit-clock edge samples data and which edge samples sync. The sync polarity and a sync-to-first-bit delay are also set at run time. A common-pins mode lets transmit follow the receive clock and sync. A single enable gates both sequencers. The table is written through a simple write port. It comes out of reset with every entry holding only the end-of-frame flag.

Top module: `tsa_seq`

## Requirements
- R1: A table write stores a 32-bit word whose bit 16 is the end-of-frame flag, bits 21:18 the run count and bits 24:22 the channel code. Addresses 0 to DEPTH/2-1 form the receive region and DEPTH/2 to DEPTH-1 the transmit region. Each sequencer reads only its own region, starting at its first entry, and its pointer wraps within that region.
- R2: The run count holds the number of slots minus one, so one entry covers 1 to 16 consecutive byte slots.
- R3: Channel codes 2 to 6 select channel index code-2 (bit code-2 of rx_strobe or tx_req). Codes 0, 1 and 7 produce no strobe.
- R4: After the last slot of an entry with the end-of-frame flag, no strobe occurs until the next frame sync, which restarts the walk at the region start.
- R5: After reset all outputs are zero and every table entry is end-of-frame, unused, count 0. An unprogrammed table therefore yields no strobes and no sync error.
- R6: Receive data is shifted MSB first. One system clock after the sampling edge of a slot's eighth bit, the owning channel's rx_strobe bit pulses high for exactly one clock, with rx_byte holding the byte.
- R7: A frame starts when sync is seen active at a sync-sampling edge after having been inactive at the previous one. Bit 0 of slot 0 is taken on the (D+1)-th data-sampling edge after that, where D (0 to 3) is the delay for the direction.
- R8: cfg_clk_fall chooses the falling (1) or rising (0) bit-clock edge for data. cfg_sync_fall chooses the edge that samples sync the same way. cfg_sync_low makes sync active low.
- R9: With cfg_common set, the transmit sequencer uses rx_bclk and rx_fsync, and tx_bclk and tx_fsync are ignored.
- R10: tx_req pulses the owning channel's bit for one clock, one system clock after the sampling edge of bit 0 of each transmit slot.
- R11: With cfg_en low, no strobe or request is produced and no frame sync is detected.
- R12: A frame sync that arrives while a walk is still running restarts the walk and sets that direction's sticky sync-error flag, which only reset clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Global enable for both sequencers |
| cfg_clk_fall | input | 1 | Data sampled on falling bit-clock edge when 1 |
| cfg_sync_fall | input | 1 | Sync sampled on falling bit-clock edge when 1 |
| cfg_sync_low | input | 1 | Sync is active low when 1 |
| cfg_common | input | 1 | Transmit uses receive clock and sync |
| cfg_rx_fsd | input | 2 | Receive sync-to-data delay in bit clocks |
| cfg_tx_fsd | input | 2 | Transmit sync-to-data delay in bit clocks |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | $clog2(DEPTH) | Table write address |
| tbl_wdata | input | 32 | Table write word |
| rx_bclk | input | 1 | Receive bit clock |
| rx_fsync | input | 1 | Receive frame sync |
| rx_data | input | 1 | Receive serial data |
| tx_bclk | input | 1 | Transmit bit clock |
| tx_fsync | input | 1 | Transmit frame sync |
| rx_strobe | output | 5 | Per-channel received-byte strobe |
| rx_byte | output | 8 | Last byte delivered to a channel |
| tx_req | output | 5 | Per-channel transmit slot request |
| rx_sync_err | output | 1 | Sticky receive early-sync flag |
| tx_sync_err | output | 1 | Sticky transmit early-sync flag |

## Verification
A bad table pointer or slot counter first shows up at the first slot boundary after the fault, within eight bit clocks. From there the strobes land on the wrong channel, arrive one slot early or late, or keep going after the end-of-frame run. A bit counter that is off by one shows within one slot, as a rotated rx_byte. A walker that fails to stop at the end-of-frame flag shows at the next frame sync, as a spurious sticky sync error. A wrong delay or edge setting shifts every byte of the frame. The bench checks each frame's full list of channel events against a model that walks the table, across every combination of delay, data edge, sync edge and sync polarity.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
  localparam int NCH      = 5;
  localparam int LAST_BIT = 16;
  localparam int CNT_LSB  = 18;
  localparam int CNT_W    = 4;
  localparam int CSEL_LSB = 22;
  localparam int CSEL_W   = 3;
  localparam int CSEL_BASE = 2;

  typedef struct packed {
    logic              last;
    logic [CNT_W-1:0]  cnt;
    logic [CSEL_W-1:0] csel;
  } route_t;

  localparam route_t ROUTE_RESET = '{last: 1'b1, cnt: '0, csel: '0};

  function automatic route_t route_decode(input logic [31:0] w);
    route_t r;
    r.last = w[LAST_BIT];
    r.cnt  = w[CNT_LSB +: CNT_W];
    r.csel = w[CSEL_LSB +: CSEL_W];
    return r;
  endfunction

  function automatic logic [NCH-1:0] csel_onehot(input logic [CSEL_W-1:0] c);
    logic [NCH-1:0] oh;
    for (int i = 0; i < NCH; i++) begin
      oh[i] = (c == CSEL_W'(i + CSEL_BASE));
    end
    return oh;
  endfunction
endpackage

// File: rtl/tsa_front.sv
module tsa_front (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic bclk,
  input  logic fsync,
  input  logic clk_fall,
  input  logic sync_fall,
  input  logic sync_low,
  output logic data_evt,
  output logic frame_start
);
  logic bclk_q, bclk_d;
  logic sync_q, sync_d;
  logic rise, fall, sync_evt, sync_lvl;

  always_comb begin
    rise        = bclk & ~bclk_q;
    fall        = ~bclk & bclk_q;
    sync_evt    = sync_fall ? fall : rise;
    sync_lvl    = fsync ^ sync_low;
    data_evt    = en & (clk_fall ? fall : rise);
    frame_start = en & sync_evt & sync_lvl & ~sync_q;
    bclk_d      = bclk;
    sync_d      = sync_evt ? sync_lvl : sync_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      bclk_q <= bclk_d;
      sync_q <= sync_d;
    end
  end

  a_r7_start_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);
endmodule

// File: rtl/tsa_route_table.sv
module tsa_route_table
  import tsa_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int HAW   = AW - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [HAW-1:0] rx_ptr,
  input  logic [HAW-1:0] tx_ptr,
  output route_t        rx_ent,
  output route_t        tx_ent
);
  route_t mem [DEPTH];
  route_t wr_ent;

  assign wr_ent = route_decode(wdata);

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic hit;
    assign hit = we && (waddr == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[g] <= ROUTE_RESET;
      end else if (hit) begin
        mem[g] <= wr_ent;
      end
    end
  end

  assign rx_ent = mem[{1'b0, rx_ptr}];
  assign tx_ent = mem[{1'b1, tx_ptr}];
endmodule

// File: rtl/tsa_walker.sv
module tsa_walker
  import tsa_pkg::*;
#(
  parameter int HAW        = 3,
  parameter int STROBE_BIT = 7,
  parameter bit CAPTURE    = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           data_evt,
  input  logic           frame_start,
  input  logic           din,
  input  logic [1:0]     fsd,
  input  route_t         ent,
  output logic [HAW-1:0] ptr,
  output logic [NCH-1:0] pulse,
  output logic [7:0]     byte_q,
  output logic           sync_err
);
  typedef enum logic [1:0] {W_IDLE, W_WAIT, W_RUN} wstate_t;

  wstate_t          st_q, st_d;
  logic [HAW-1:0]   ptr_q, ptr_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic [2:0]       bit_q, bit_d;
  logic [1:0]       skip_q, skip_d;
  logic             err_q, err_d;
  logic [NCH-1:0]   pulse_q, pulse_d;
  logic             take;
  logic [NCH-1:0]   chan_oh;

  assign chan_oh = csel_onehot(ent.csel);

  always_comb begin
    st_d    = st_q;
    ptr_d   = ptr_q;
    idx_d   = idx_q;
    bit_d   = bit_q;
    skip_d  = skip_q;
    err_d   = err_q;
    pulse_d = '0;
    take    = data_evt & ~frame_start &
              ((st_q == W_RUN) | ((st_q == W_WAIT) & (skip_q == 2'd0)));
    if (!en) begin
      st_d = W_IDLE;
    end else if (frame_start) begin
      err_d  = err_q | (st_q == W_RUN);
      st_d   = W_WAIT;
      skip_d = fsd;
      ptr_d  = '0;
      idx_d  = '0;
      bit_d  = '0;
    end else if (data_evt && (st_q == W_WAIT) && (skip_q != 2'd0)) begin
      skip_d = skip_q - 2'd1;
    end else if (take) begin
      st_d  = W_RUN;
      bit_d = bit_q + 3'd1;
      if (bit_q == 3'(STROBE_BIT)) pulse_d = chan_oh;
      if (bit_q == 3'd7) begin
        if (idx_q == ent.cnt) begin
          idx_d = '0;
          if (ent.last) st_d = W_IDLE;
          else          ptr_d = ptr_q + HAW'(1);
        end else begin
          idx_d = idx_q + CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= W_IDLE;
      ptr_q   <= '0;
      idx_q   <= '0;
      bit_q   <= '0;
      skip_q  <= '0;
      err_q   <= 1'b0;
      pulse_q <= '0;
    end else begin
      st_q    <= st_d;
      ptr_q   <= ptr_d;
      idx_q   <= idx_d;
      bit_q   <= bit_d;
      skip_q  <= skip_d;
      err_q   <= err_d;
      pulse_q <= pulse_d;
    end
  end

  if (CAPTURE) begin : g_capture
    logic [6:0] sh_q, sh_d;
    logic [7:0] byte_r, byte_d;
    logic       sh_en, byte_en;
    always_comb begin
      sh_en   = take;
      byte_en = take && (bit_q == 3'd7) && (|chan_oh);
      sh_d    = {sh_q[5:0], din};
      byte_d  = {sh_q, din};
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q   <= '0;
        byte_r <= '0;
      end else begin
        if (sh_en)   sh_q   <= sh_d;
        if (byte_en) byte_r <= byte_d;
      end
    end
    assign byte_q = byte_r;
  end else begin : g_nocapture
    logic unused_din;
    assign unused_din = din;
    assign byte_q     = '0;
  end

  assign ptr      = ptr_q;
  assign pulse    = pulse_q;
  assign sync_err = err_q;

  a_r6_pulse_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pulse_q));
  a_r6_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q != '0) |=> (pulse_q == '0));
  a_r12_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  a_r12_restart_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (en && frame_start) |=> (ptr_q == '0));
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == W_IDLE) |=> (pulse_q == '0));
endmodule

// File: rtl/tsa_seq.sv
module tsa_seq
  import tsa_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_en,
  input  logic                     cfg_clk_fall,
  input  logic                     cfg_sync_fall,
  input  logic                     cfg_sync_low,
  input  logic                     cfg_common,
  input  logic [1:0]               cfg_rx_fsd,
  input  logic [1:0]               cfg_tx_fsd,
  input  logic                     tbl_we,
  input  logic [$clog2(DEPTH)-1:0] tbl_addr,
  input  logic [31:0]              tbl_wdata,
  input  logic                     rx_bclk,
  input  logic                     rx_fsync,
  input  logic                     rx_data,
  input  logic                     tx_bclk,
  input  logic                     tx_fsync,
  output logic [4:0]               rx_strobe,
  output logic [7:0]               rx_byte,
  output logic [4:0]               tx_req,
  output logic                     rx_sync_err,
  output logic                     tx_sync_err
);
  localparam int AW  = $clog2(DEPTH);
  localparam int HAW = AW - 1;

  logic           rx_evt, rx_start, tx_evt, tx_start;
  logic           tx_bclk_sel, tx_fsync_sel;
  logic [HAW-1:0] rx_ptr, tx_ptr;
  route_t         rx_ent, tx_ent;
  logic [7:0]     unused_tx_byte;

  assign tx_bclk_sel  = cfg_common ? rx_bclk  : tx_bclk;
  assign tx_fsync_sel = cfg_common ? rx_fsync : tx_fsync;

  tsa_front u_rx_front (
    .clk(clk), .rst_n(rst_n), .en(cfg_en), .bclk(rx_bclk), .fsync(rx_fsync),
    .clk_fall(cfg_clk_fall), .sync_fall(cfg_sync_fall), .sync_low(cfg_sync_low),
    .data_evt(rx_evt), .frame_start(rx_start)
  );

  tsa_front u_tx_front (
    .clk(clk), .rst_n(rst_n), .en(cfg_en), .bclk(tx_bclk_sel), .fsync(tx_fsync_sel),
    .clk_fall(cfg_clk_fall), .sync_fall(cfg_sync_fall), .sync_low(cfg_sync_low),
    .data_evt(tx_evt), .frame_start(tx_start)
  );

  tsa_route_table #(.DEPTH(DEPTH), .AW(AW), .HAW(HAW)) u_table (
    .clk(clk), .rst_n(rst_n), .we(tbl_we), .waddr(tbl_addr), .wdata(tbl_wdata),
    .rx_ptr(rx_ptr), .tx_ptr(tx_ptr), .rx_ent(rx_ent), .tx_ent(tx_ent)
  );

  tsa_walker #(.HAW(HAW), .STROBE_BIT(7), .CAPTURE(1'b1)) u_rx_walk (
    .clk(clk), .rst_n(rst_n), .en(cfg_en), .data_evt(rx_evt), .frame_start(rx_start),
    .din(rx_data), .fsd(cfg_rx_fsd), .ent(rx_ent), .ptr(rx_ptr),
    .pulse(rx_strobe), .byte_q(rx_byte), .sync_err(rx_sync_err)
  );

  tsa_walker #(.HAW(HAW), .STROBE_BIT(0), .CAPTURE(1'b0)) u_tx_walk (
    .clk(clk), .rst_n(rst_n), .en(cfg_en), .data_evt(tx_evt), .frame_start(tx_start),
    .din(1'b0), .fsd(cfg_tx_fsd), .ent(tx_ent), .ptr(tx_ptr),
    .pulse(tx_req), .byte_q(unused_tx_byte), .sync_err(tx_sync_err)
  );

  a_r11_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> ((rx_strobe == '0) && (tx_req == '0)));
  a_r10_tx_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_req));
endmodule

// File: tb/tb_tsa_seq.sv
module tb_tsa_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int HALF       = DEPTH / 2;
  localparam int PH         = 2;
  localparam int CAP        = 1024;

  logic clk, rst_n;
  logic cfg_en, cfg_clk_fall, cfg_sync_fall, cfg_sync_low, cfg_common;
  logic [1:0] cfg_rx_fsd, cfg_tx_fsd;
  logic tbl_we;
  logic [3:0] tbl_addr;
  logic [31:0] tbl_wdata;
  logic rx_bclk, rx_fsync, rx_data, tx_bclk, tx_fsync;
  logic [4:0] rx_strobe, tx_req;
  logic [7:0] rx_byte;
  logic rx_sync_err, tx_sync_err;

  tsa_seq #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_clk_fall(cfg_clk_fall),
    .cfg_sync_fall(cfg_sync_fall), .cfg_sync_low(cfg_sync_low), .cfg_common(cfg_common),
    .cfg_rx_fsd(cfg_rx_fsd), .cfg_tx_fsd(cfg_tx_fsd), .tbl_we(tbl_we),
    .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata), .rx_bclk(rx_bclk), .rx_fsync(rx_fsync),
    .rx_data(rx_data), .tx_bclk(tx_bclk), .tx_fsync(tx_fsync), .rx_strobe(rx_strobe),
    .rx_byte(rx_byte), .tx_req(tx_req), .rx_sync_err(rx_sync_err),
    .tx_sync_err(tx_sync_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int m_last [DEPTH];
  int m_cnt  [DEPTH];
  int m_cs   [DEPTH];
  int g_rx_ch [CAP];
  int g_rx_b  [CAP];
  int g_tx_ch [CAP];
  int g_rx_n = 0;
  int g_tx_n = 0;
  int e_rx_ch [CAP];
  int e_rx_b  [CAP];
  int e_tx_ch [CAP];
  int e_rx_n, e_tx_n;

  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < 5; i++) begin
        if (rx_strobe[i]) begin
          if (g_rx_n < CAP) begin
            g_rx_ch[g_rx_n] = i;
            g_rx_b[g_rx_n]  = int'(rx_byte);
          end
          g_rx_n++;
        end
        if (tx_req[i]) begin
          if (g_tx_n < CAP) g_tx_ch[g_tx_n] = i;
          g_tx_n++;
        end
      end
    end
  end

  function automatic logic [7:0] byte_of(input int seed, input int s);
    return 8'((s * 37 + seed * 11 + 5) & 255);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int last, input int cnt, input int cs);
    @(negedge clk);
    tbl_we    = 1'b1;
    tbl_addr  = 4'(addr);
    tbl_wdata = (32'(last) << 16) | (32'(cnt) << 18) | (32'(cs) << 22) | 32'h0002_0000;
    @(negedge clk);
    tbl_we = 1'b0;
    m_last[addr] = last;
    m_cnt[addr]  = cnt;
    m_cs[addr]   = cs;
  endtask

  task automatic model(input bit tx, input int nslots, input int seed);
    int base, ptr, idx, cs;
    bit done;
    base = tx ? HALF : 0;
    ptr = 0; idx = 0; done = 0;
    for (int s = 0; s < nslots; s++) begin
      if (!done) begin
        cs = m_cs[base + ptr];
        if (cs >= 2 && cs <= 6) begin
          if (tx) begin
            e_tx_ch[e_tx_n] = cs - 2; e_tx_n++;
          end else begin
            e_rx_ch[e_rx_n] = cs - 2; e_rx_b[e_rx_n] = int'(byte_of(seed, s)); e_rx_n++;
          end
        end
        if (idx == m_cnt[base + ptr]) begin
          idx = 0;
          if (m_last[base + ptr] != 0) done = 1;
          else ptr = (ptr + 1) % HALF;
        end else begin
          idx++;
        end
      end
    end
  endtask

  task automatic run_frame(input bit tx, input int nslots, input int seed,
                           input int pre, input int post);
    int fsd, sp, first, last;
    logic [7:0] bv;
    logic d, s;
    fsd   = tx ? int'(cfg_tx_fsd) : int'(cfg_rx_fsd);
    sp    = (cfg_sync_fall == cfg_clk_fall) ? (-1 - fsd) : -fsd;
    first = sp - pre;
    last  = nslots * 8 - 1 + post;
    for (int p = first; p <= last; p++) begin
      d = 1'b1;
      if (p >= 0 && p < nslots * 8) begin
        bv = byte_of(seed, p / 8);
        d  = bv[7 - (p % 8)];
      end
      s = (p == sp);
      @(negedge clk);
      rx_data = d;
      if (tx) begin
        tx_fsync = s ^ cfg_sync_low; tx_bclk = cfg_clk_fall;
      end else begin
        rx_fsync = s ^ cfg_sync_low; rx_bclk = cfg_clk_fall;
      end
      repeat (PH - 1) @(negedge clk);
      @(negedge clk);
      if (tx) tx_bclk = ~cfg_clk_fall;
      else    rx_bclk = ~cfg_clk_fall;
      repeat (PH - 1) @(negedge clk);
    end
  endtask

  task automatic cmp_rx(input string req, input int base);
    int n;
    n = g_rx_n - base;
    check(n == e_rx_n, {req, " rx event count"}, n, e_rx_n);
    for (int k = 0; k < e_rx_n && k < n; k++) begin
      check(g_rx_ch[base + k] == e_rx_ch[k], {req, " rx channel"}, g_rx_ch[base + k], e_rx_ch[k]);
      check(g_rx_b[base + k] == e_rx_b[k], {req, " rx byte"}, g_rx_b[base + k], e_rx_b[k]);
    end
  endtask

  task automatic cmp_tx(input string req, input int base);
    int n;
    n = g_tx_n - base;
    check(n == e_tx_n, {req, " tx event count"}, n, e_tx_n);
    for (int k = 0; k < e_tx_n && k < n; k++) begin
      check(g_tx_ch[base + k] == e_tx_ch[k], {req, " tx channel"}, g_tx_ch[base + k], e_tx_ch[k]);
    end
  endtask

  task automatic prog_t1();
    wr(0, 0, 1, 2);
    wr(1, 0, 0, 0);
    wr(2, 0, 2, 6);
    wr(3, 0, 0, 1);
    wr(4, 1, 1, 4);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    int rb, tb;
    rst_n = 1'b0;
    cfg_en = 1'b1; cfg_clk_fall = 1'b0; cfg_sync_fall = 1'b0; cfg_sync_low = 1'b0;
    cfg_common = 1'b0; cfg_rx_fsd = 2'd0; cfg_tx_fsd = 2'd0;
    tbl_we = 1'b0; tbl_addr = '0; tbl_wdata = '0;
    rx_bclk = 1'b0; rx_fsync = 1'b0; rx_data = 1'b0; tx_bclk = 1'b0; tx_fsync = 1'b0;
    e_rx_n = 0; e_tx_n = 0;
    for (int i = 0; i < DEPTH; i++) begin
      m_last[i] = 1; m_cnt[i] = 0; m_cs[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: reset state
    check(rx_strobe == 5'd0, "R5 rx_strobe reset", int'(rx_strobe), 0);
    check(rx_byte == 8'd0, "R5 rx_byte reset", int'(rx_byte), 0);
    check(tx_req == 5'd0, "R5 tx_req reset", int'(tx_req), 0);
    check(rx_sync_err == 1'b0 && tx_sync_err == 1'b0, "R5 sync_err reset",
          int'({rx_sync_err, tx_sync_err}), 0);

    // R5: unprogrammed table ends the frame at once; two frames, no error
    rb = g_rx_n; e_rx_n = 0;
    run_frame(0, 4, 1, 2, 0);
    run_frame(0, 4, 2, 0, 2);
    cmp_rx("R5", rb);
    check(rx_sync_err == 1'b0, "R5 no sync error on empty table", int'(rx_sync_err), 0);

    // R1 R3 R6 R4: mixed table, frame one slot longer than the table
    prog_t1();
    rb = g_rx_n; e_rx_n = 0;
    model(0, 10, 3);
    run_frame(0, 10, 3, 2, 2);
    cmp_rx("R1 R3 R4 R6", rb);

    // R2: one entry covering 16 slots, frame of 17
    wr(0, 1, 15, 3);
    rb = g_rx_n; e_rx_n = 0;
    model(0, 17, 4);
    run_frame(0, 17, 4, 2, 2);
    cmp_rx("R2", rb);

    // R7 R8: sweep delay, data edge, sync edge, sync polarity; code 7 invalid
    wr(0, 0, 0, 3);
    wr(1, 0, 0, 7);
    wr(2, 1, 0, 5);
    for (int fs = 0; fs < 4; fs++) begin
      for (int cf = 0; cf < 2; cf++) begin
        for (int sf = 0; sf < 2; sf++) begin
          for (int sl = 0; sl < 2; sl++) begin
            @(negedge clk);
            cfg_rx_fsd = 2'(fs); cfg_clk_fall = cf[0];
            cfg_sync_fall = sf[0]; cfg_sync_low = sl[0];
            rb = g_rx_n; e_rx_n = 0;
            model(0, 4, 10 + fs * 8 + cf * 4 + sf * 2 + sl);
            run_frame(0, 4, 10 + fs * 8 + cf * 4 + sf * 2 + sl, 2, 2);
            cmp_rx("R7 R8", rb);
          end
        end
      end
    end

    // R9 R10: transmit follows receive clock and sync
    @(negedge clk);
    cfg_clk_fall = 1'b0; cfg_sync_fall = 1'b0; cfg_sync_low = 1'b0;
    cfg_rx_fsd = 2'd1; cfg_tx_fsd = 2'd1; cfg_common = 1'b1;
    prog_t1();
    wr(HALF + 0, 0, 1, 5);
    wr(HALF + 1, 1, 0, 2);
    rb = g_rx_n; tb = g_tx_n; e_rx_n = 0; e_tx_n = 0;
    model(0, 10, 50);
    model(1, 10, 50);
    run_frame(0, 10, 50, 2, 2);
    cmp_rx("R1 R9", rb);
    cmp_tx("R9 R10", tb);

    // R10: transmit on its own clock and sync, receive idle
    @(negedge clk);
    cfg_common = 1'b0; cfg_tx_fsd = 2'd2;
    rb = g_rx_n; tb = g_tx_n; e_rx_n = 0; e_tx_n = 0;
    model(1, 4, 60);
    run_frame(1, 4, 60, 2, 2);
    cmp_rx("R10 rx idle", rb);
    cmp_tx("R10", tb);

    // R11: disabled sequencers stay silent
    @(negedge clk);
    cfg_en = 1'b0; cfg_rx_fsd = 2'd0;
    rb = g_rx_n; e_rx_n = 0;
    run_frame(0, 5, 70, 2, 0);
    run_frame(0, 10, 71, 0, 2);
    cmp_rx("R11", rb);
    check(rx_sync_err == 1'b0, "R11 no sync detection when disabled", int'(rx_sync_err), 0);

    // R12: early sync restarts the walk and sets the sticky flag
    @(negedge clk);
    cfg_en = 1'b1;
    check(tx_sync_err == 1'b0, "R12 tx flag clear before", int'(tx_sync_err), 0);
    rb = g_rx_n; e_rx_n = 0;
    model(0, 5, 80);
    model(0, 10, 81);
    run_frame(0, 5, 80, 2, 0);
    run_frame(0, 10, 81, 0, 2);
    cmp_rx("R12", rb);
    check(rx_sync_err == 1'b1, "R12 rx sticky flag set", int'(rx_sync_err), 1);
    rb = g_rx_n; e_rx_n = 0;
    model(0, 10, 82);
    run_frame(0, 10, 82, 2, 2);
    cmp_rx("R12 after restart", rb);
    check(rx_sync_err == 1'b1, "R12 rx flag stays set", int'(rx_sync_err), 1);
    check(tx_sync_err == 1'b0, "R12 tx flag untouched", int'(tx_sync_err), 0);

    summary();
    $finish;
  end
endmodule